// File: doc/BRIEF.md
# Wakeup-Gated Asynchronous Serial Receiver

This block receives asynchronous serial characters from a line shared by several nodes, using a 16x oversampling enable. It frames either a 10-bit character (start, eight data bits, stop) or an 11-bit character, which carries a ninth bit between the data and the stop bit. Each accepted character appears on a data register with a ready flag. The block also reports framing and overrun errors and keeps an idle-line status.

A sleep flag lets a node ignore traffic meant for other nodes. While the flag is set, completed characters are discarded. What releases the flag depends on a mode input. In idle mode the flag clears when the line has been idle for a full frame time. In address mode it clears on a received character whose ninth bit is one, and that character is delivered. The block never sets the sleep flag itself. The host sets it with a one-cycle strobe.

The idle detector raises a one-cycle event once per idle period and latches it as a pending flag. When enabled, the pending flag drives an interrupt until the host acknowledges it.

Top module: `wake_uart_rx`

## Requirements
- R1: With `cfg_nine_i`=0, a frame of one low start bit, eight data bits sent least significant first and a high stop bit sets `ready_o` and puts the byte on `data_o`, with `bit9_o`=0.
- R2: With `cfg_nine_i`=1, the bit that follows the eight data bits is the ninth bit and appears on `bit9_o`; the stop bit comes after it.
- R3: A low pulse that has ended by the middle of the start-bit time (8 oversampling ticks) is rejected. No character is delivered, and `ready_o` and `data_o` are unchanged.
- R4: A `sleep_set_i` strobe sets `sleep_o`. While `sleep_o`=1, a completed character that does not meet the address-wake condition of R8 leaves `ready_o`, `data_o` and `bit9_o` unchanged.
- R5: `idle_o` rises once the line has been high for (frame bits × 16) consecutive ticks: 160 ticks in the 10-bit format and 176 in the 11-bit format. It clears when the line goes low.
- R6: `idle_evt_o` pulses for one cycle, only when `idle_o` rises, so once per idle period. The pulse sets a pending flag that the `idle_ack_i` strobe clears. `idle_irq_o` is the pending flag gated by `cfg_idle_ie_i`.
- R7: With `cfg_wake_addr_i`=0, the idle event clears `sleep_o`, and the next character is delivered.
- R8: With `cfg_wake_addr_i`=1 and the block asleep, a character whose ninth bit is 1 clears `sleep_o` and is delivered with `bit9_o`=1. A character whose ninth bit is 0 is dropped, and an idle event leaves `sleep_o` set.
- R9: `sleep_o` rises only after a `sleep_set_i` strobe. It stays clear across later characters and idle periods until the host strobes it again.
- R10: A stop bit sampled low sets `frame_err_o`. While `ready_o` is set with an error flag, `rx_exc_irq_o`=1 and `rx_irq_o`=0. Without an error flag, `rx_irq_o`=1.
- R11: A character delivered while `ready_o` is still set and is not being read in the same cycle sets `overrun_o`, and `data_o` takes the new character.
- R12: A `data_rd_i` strobe clears `ready_o`, `frame_err_o` and `overrun_o`.
- R13: After reset, `ready_o`, `sleep_o`, `idle_o`, the error flags and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Serial line input; idles high |
| cfg_nine_i | input | 1 | 1 = 11-bit format with a ninth bit |
| cfg_wake_addr_i | input | 1 | Wake select: 0 = idle line, 1 = ninth-bit address |
| cfg_idle_ie_i | input | 1 | Enable for the idle interrupt |
| sleep_set_i | input | 1 | Strobe that sets the sleep flag |
| data_rd_i | input | 1 | Host read strobe |
| idle_ack_i | input | 1 | Idle interrupt acknowledge strobe |
| data_o | output | DATA_W | Last delivered byte |
| bit9_o | output | 1 | Ninth bit of the last delivered character |
| ready_o | output | 1 | Character waiting to be read |
| sleep_o | output | 1 | Sleep flag |
| idle_o | output | 1 | Line is idle |
| idle_evt_o | output | 1 | One-cycle pulse at the start of an idle period |
| idle_irq_o | output | 1 | Idle interrupt request |
| frame_err_o | output | 1 | Framing error of the held character |
| overrun_o | output | 1 | Overrun occurred |
| rx_irq_o | output | 1 | Plain receive request |
| rx_exc_irq_o | output | 1 | Receive-with-error request |

## Verification
The properties assume that the format and wake-select inputs stay constant while a character is in flight. They also assume that the host never strobes `sleep_set_i` in the same cycle that a wakeup happens. The stimulus changes configuration only while the line is high between characters, and it issues every strobe at least a bit time away from a character's stop sample. Oversampling ticks arrive every clock, so a bit lasts exactly 16 cycles and the expected values in the bench can be tied to whole bit times.

// File: rtl/wake_uart_rx_pkg.sv
package wake_uart_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_e;

   // ticks of continuous high line that make up one whole frame
   function automatic int frame_ticks(input int dbits, input bit nine, input int osr);
      return (dbits + 2 + (nine ? 1 : 0)) * osr;
   endfunction

endpackage

// File: rtl/wur_sync.sv
module wur_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wur_deframer.sv
module wur_deframer
   import wake_uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              nine_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              b9_o,
   output logic              ferr_o
);
   localparam int CW = $clog2(OSR);
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] MID_T = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] END_T = CW'(OSR - 1);

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic [BW-1:0]     last_idx;
   logic [DATA_W:0]   sh;
   logic              nine_q;
   logic              armed;

   assign last_idx = nine_q ? BW'(DATA_W) : BW'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         sh     <= '0;
         nine_q <= 1'b0;
         armed  <= 1'b0;
         done_o <= 1'b0;
         data_o <= '0;
         b9_o   <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (rx_i) begin
                  armed <= 1'b1;
               end else if (tick_i && armed) begin
                  st     <= ST_START;
                  cnt    <= '0;
                  nine_q <= nine_i;
               end
            end
            ST_START: if (tick_i) begin
               if (cnt == MID_T) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= rx_i ? ST_IDLE : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: if (tick_i) begin
               if (cnt == END_T) begin
                  cnt <= '0;
                  sh  <= {rx_i, sh[DATA_W:1]};
                  if (bidx == last_idx) st <= ST_STOP;
                  else                  bidx <= bidx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: if (tick_i) begin
               if (cnt == END_T) begin
                  cnt    <= '0;
                  st     <= ST_IDLE;
                  armed  <= 1'b0;
                  done_o <= 1'b1;
                  ferr_o <= ~rx_i;
                  data_o <= nine_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
                  b9_o   <= nine_q & sh[DATA_W];
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wur_idle_det.sv
module wur_idle_det
   import wake_uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rx_i,
   input  logic nine_i,
   output logic idle_o,
   output logic evt_o
);
   localparam int IW = $clog2(frame_ticks(DATA_W, 1'b1, OSR) + 1);
   localparam logic [IW-1:0] THR_SHORT = IW'(frame_ticks(DATA_W, 1'b0, OSR));
   localparam logic [IW-1:0] THR_LONG  = IW'(frame_ticks(DATA_W, 1'b1, OSR));

   logic [IW-1:0] cnt;
   logic [IW-1:0] thr;

   assign thr = nine_i ? THR_LONG : THR_SHORT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         idle_o <= 1'b0;
         evt_o  <= 1'b0;
      end else begin
         evt_o <= 1'b0;
         if (!rx_i) begin
            cnt    <= '0;
            idle_o <= 1'b0;
         end else if (tick_i && !idle_o) begin
            if (cnt >= thr - 1'b1) begin
               idle_o <= 1'b1;
               evt_o  <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wur_wake_ctl.sv
module wur_wake_ctl #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              b9_i,
   input  logic              ferr_i,
   input  logic              idle_evt_i,
   input  logic              wake_addr_i,
   input  logic              idle_ie_i,
   input  logic              sleep_set_i,
   input  logic              rd_i,
   input  logic              ack_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              ready_o,
   output logic              ferr_o,
   output logic              ovr_o,
   output logic              sleep_o,
   output logic              idle_irq_o,
   output logic              rx_irq_o,
   output logic              rx_exc_o
);
   logic addr_hit;
   logic accept;
   logic pend;

   assign addr_hit = done_i & wake_addr_i & b9_i;
   assign accept   = done_i & (~sleep_o | addr_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         bit9_o  <= 1'b0;
         ready_o <= 1'b0;
         ferr_o  <= 1'b0;
         ovr_o   <= 1'b0;
         sleep_o <= 1'b0;
         pend    <= 1'b0;
      end else begin
         if (sleep_set_i)                     sleep_o <= 1'b1;
         else if (sleep_o && addr_hit)        sleep_o <= 1'b0;
         else if (idle_evt_i && !wake_addr_i) sleep_o <= 1'b0;

         if (accept) begin
            data_o  <= data_i;
            bit9_o  <= b9_i;
            ready_o <= 1'b1;
            ferr_o  <= ferr_i;
            ovr_o   <= ready_o & ~rd_i;
         end else if (rd_i) begin
            ready_o <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
         end

         if (idle_evt_i) pend <= 1'b1;
         else if (ack_i) pend <= 1'b0;
      end
   end

   assign idle_irq_o = pend & idle_ie_i;
   assign rx_irq_o   = ready_o & ~(ferr_o | ovr_o);
   assign rx_exc_o   = ready_o & (ferr_o | ovr_o);
endmodule

// File: rtl/wake_uart_rx.sv
module wake_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16_i,
   input  logic              rxd_i,
   input  logic              cfg_nine_i,
   input  logic              cfg_wake_addr_i,
   input  logic              cfg_idle_ie_i,
   input  logic              sleep_set_i,
   input  logic              data_rd_i,
   input  logic              idle_ack_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              ready_o,
   output logic              sleep_o,
   output logic              idle_o,
   output logic              idle_evt_o,
   output logic              idle_irq_o,
   output logic              frame_err_o,
   output logic              overrun_o,
   output logic              rx_irq_o,
   output logic              rx_exc_irq_o
);
   logic              rx_s;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_b9;
   logic              fr_ferr;

   wur_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rx_s)
   );

   wur_deframer #(.DATA_W(DATA_W), .OSR(OSR)) u_deframer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick16_i),
      .rx_i   (rx_s),
      .nine_i (cfg_nine_i),
      .done_o (fr_done),
      .data_o (fr_data),
      .b9_o   (fr_b9),
      .ferr_o (fr_ferr)
   );

   wur_idle_det #(.DATA_W(DATA_W), .OSR(OSR)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick16_i),
      .rx_i   (rx_s),
      .nine_i (cfg_nine_i),
      .idle_o (idle_o),
      .evt_o  (idle_evt_o)
   );

   wur_wake_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (fr_done),
      .data_i      (fr_data),
      .b9_i        (fr_b9),
      .ferr_i      (fr_ferr),
      .idle_evt_i  (idle_evt_o),
      .wake_addr_i (cfg_wake_addr_i),
      .idle_ie_i   (cfg_idle_ie_i),
      .sleep_set_i (sleep_set_i),
      .rd_i        (data_rd_i),
      .ack_i       (idle_ack_i),
      .data_o      (data_o),
      .bit9_o      (bit9_o),
      .ready_o     (ready_o),
      .ferr_o      (frame_err_o),
      .ovr_o       (overrun_o),
      .sleep_o     (sleep_o),
      .idle_irq_o  (idle_irq_o),
      .rx_irq_o    (rx_irq_o),
      .rx_exc_o    (rx_exc_irq_o)
   );
endmodule

// File: rtl/wake_uart_rx_chk.sv
module wake_uart_rx_chk #(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick16_i,
   input logic              rxd_i,
   input logic              cfg_nine_i,
   input logic              cfg_wake_addr_i,
   input logic              cfg_idle_ie_i,
   input logic              sleep_set_i,
   input logic              data_rd_i,
   input logic              idle_ack_i,
   input logic [DATA_W-1:0] data_o,
   input logic              bit9_o,
   input logic              ready_o,
   input logic              sleep_o,
   input logic              idle_o,
   input logic              idle_evt_o,
   input logic              idle_irq_o,
   input logic              frame_err_o,
   input logic              overrun_o,
   input logic              rx_irq_o,
   input logic              rx_exc_irq_o
);
   initial begin
      a_param_osr : assert (OSR >= 4 && (OSR % 2) == 0)
         else $error("OSR must be even and at least 4");
      a_param_width : assert (DATA_W >= 5 && DATA_W <= 16)
         else $error("DATA_W out of range");
      a_param_sync : assert (SYNC_STAGES >= 1)
         else $error("SYNC_STAGES must be at least 1");
   end

   // R4 / R8: a delivery out of sleep only happens through an address character
   p_sleep_gate_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready_o) && $past(sleep_o)) |-> (cfg_wake_addr_i && bit9_o));

   // R5: the idle event coincides with the idle status being set
   p_idle_level_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt_o |-> idle_o);

   // R6: the event only fires at the start of an idle period
   p_idle_once_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt_o |-> !$past(idle_o));

   // R6: no interrupt while disabled
   p_idle_irq_en_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_irq_o |-> cfg_idle_ie_i);

   // R6: acknowledge drops the request
   p_idle_ack_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (idle_ack_i && !idle_evt_o) |=> !idle_irq_o);

   // R7: in idle mode the idle event releases sleep
   p_idle_wake_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (idle_evt_o && !cfg_wake_addr_i && !sleep_set_i) |=> !sleep_o);

   // R9: sleep is never entered without the host strobe
   p_no_self_sleep_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(sleep_set_i));

   // R10: an erroneous character raises the exception request only
   p_exc_route_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && (frame_err_o || overrun_o)) |-> (rx_exc_irq_o && !rx_irq_o));

   // R11: overrun needs an unread character before it
   p_overrun_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> $past(ready_o));
endmodule

bind wake_uart_rx wake_uart_rx_chk #(
   .DATA_W      (DATA_W),
   .OSR         (OSR),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/wake_uart_rx_tb_top.sv
module wake_uart_rx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CYC    = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic       rxd = 1'b1;
   logic       cfg_nine = 1'b1;
   logic       cfg_wake_addr = 1'b0;
   logic       cfg_idle_ie = 1'b0;
   logic       sleep_set = 1'b0;
   logic       data_rd = 1'b0;
   logic       idle_ack = 1'b0;
   logic [7:0] data_o;
   logic       bit9_o, ready_o, sleep_o, idle_o, idle_evt_o, idle_irq_o;
   logic       frame_err_o, overrun_o, rx_irq_o, rx_exc_irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   int evt_seen = 0;

   // reference model state
   logic [7:0] m_data = 8'h00;
   bit m_b9 = 0, m_ready = 0, m_fe = 0, m_ov = 0, m_sleep = 0, m_pend = 0, m_idle = 0;
   int m_evt = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wake_uart_rx dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick16_i        (tick16),
      .rxd_i           (rxd),
      .cfg_nine_i      (cfg_nine),
      .cfg_wake_addr_i (cfg_wake_addr),
      .cfg_idle_ie_i   (cfg_idle_ie),
      .sleep_set_i     (sleep_set),
      .data_rd_i       (data_rd),
      .idle_ack_i      (idle_ack),
      .data_o          (data_o),
      .bit9_o          (bit9_o),
      .ready_o         (ready_o),
      .sleep_o         (sleep_o),
      .idle_o          (idle_o),
      .idle_evt_o      (idle_evt_o),
      .idle_irq_o      (idle_irq_o),
      .frame_err_o     (frame_err_o),
      .overrun_o       (overrun_o),
      .rx_irq_o        (rx_irq_o),
      .rx_exc_irq_o    (rx_exc_irq_o)
   );

   always @(negedge clk) if (rst_n && idle_evt_o) evt_seen++;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "ready_o",      ready_o,      m_ready);
      check(tag, "data_o",       data_o,       m_data);
      check(tag, "bit9_o",       bit9_o,       m_b9);
      check(tag, "frame_err_o",  frame_err_o,  m_fe);
      check(tag, "overrun_o",    overrun_o,    m_ov);
      check(tag, "sleep_o",      sleep_o,      m_sleep);
      check(tag, "idle_o",       idle_o,       m_idle);
      check(tag, "rx_irq_o",     rx_irq_o,     m_ready && !(m_fe || m_ov));
      check(tag, "rx_exc_irq_o", rx_exc_irq_o, m_ready && (m_fe || m_ov));
      check(tag, "idle_irq_o",   idle_irq_o,   m_pend && cfg_idle_ie);
      check(tag, "idle events",  evt_seen,     m_evt);
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (BIT_CYC) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input bit b9, input bit stopv, input string tag);
      bit deliver;
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      if (cfg_nine) drive_bit(b9);
      drive_bit(stopv);
      rxd = 1'b1;
      deliver = !m_sleep || (cfg_wake_addr && cfg_nine && b9);
      if (deliver) begin
         m_sleep = 0;
         m_ov    = m_ready;
         m_ready = 1;
         m_data  = d;
         m_b9    = cfg_nine ? b9 : 0;
         m_fe    = !stopv;
      end
      m_idle = 0;
      repeat (4) @(negedge clk);
      compare_all(tag);
   endtask

   task automatic host_read(input string tag);
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      m_ready = 0; m_fe = 0; m_ov = 0;
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic set_sleep(input string tag);
      sleep_set = 1'b1;
      @(negedge clk);
      sleep_set = 1'b0;
      m_sleep = 1;
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic wait_idle(input string tag);
      repeat (200) @(negedge clk);
      m_idle = 1; m_pend = 1; m_evt++;
      if (!cfg_wake_addr) m_sleep = 0;
      compare_all(tag);
   endtask

   task automatic ack_idle(input string tag);
      idle_ack = 1'b1;
      @(negedge clk);
      idle_ack = 1'b0;
      m_pend = 0;
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_all("R13");
      rst_n = 1'b1;
      // R5: 11-bit idle threshold is 176 ticks
      repeat (165) @(negedge clk);
      check("R5", "idle_o before threshold", idle_o, 0);
      repeat (25) @(negedge clk);
      m_idle = 1; m_pend = 1; m_evt = 1;
      check("R5", "idle_o after threshold", idle_o, 1);
      check("R6", "idle_irq_o while disabled", idle_irq_o, 0);
      cfg_idle_ie = 1'b1;
      @(negedge clk);
      check("R6", "idle_irq_o when enabled", idle_irq_o, 1);
      ack_idle("R6");
      repeat (500) @(negedge clk);
      compare_all("R6");

      // R1: 10-bit format
      cfg_nine = 1'b0;
      send_char(8'hA5, 0, 1, "R1");
      host_read("R12");
      // R2: 11-bit format with ninth bit
      cfg_nine = 1'b1;
      send_char(8'h3C, 1, 1, "R2");
      host_read("R12");

      // R3: short low pulse is noise
      rxd = 1'b0;
      repeat (5) @(negedge clk);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
      compare_all("R3");
      wait_idle("R3");
      ack_idle("R6");

      // R10: framing error
      cfg_nine = 1'b0;
      send_char(8'h0F, 0, 0, "R10");
      repeat (20) @(negedge clk);
      host_read("R12");

      // R11: overrun
      send_char(8'h11, 0, 1, "R11");
      send_char(8'h22, 0, 1, "R11");
      host_read("R12");

      // R4, R7: idle-line wake
      wait_idle("R5");
      ack_idle("R6");
      set_sleep("R4");
      send_char(8'h77, 0, 1, "R4");
      check("R9", "sleep_o kept", sleep_o, 1);
      wait_idle("R7");
      ack_idle("R7");
      send_char(8'h99, 0, 1, "R7");
      host_read("R12");

      // R8, R9: address wake
      cfg_wake_addr = 1'b1;
      cfg_nine = 1'b1;
      repeat (20) @(negedge clk);
      set_sleep("R8");
      send_char(8'h44, 0, 1, "R8");
      wait_idle("R8");
      ack_idle("R8");
      send_char(8'h5A, 1, 1, "R8");
      host_read("R12");
      send_char(8'h66, 0, 1, "R9");
      wait_idle("R9");
      check("R9", "sleep_o stays clear", sleep_o, 0);
      host_read("R12");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule